// File: doc/BRIEF.md
# Trigger Primitive Time Matcher

This block takes timestamped trigger primitives from several detector sources and decides which of them belong together. Each primitive carries an 8-bit condition field and a 16-bit fine timestamp counted in eighths of the 25 ns clock period. Primitives from different sources arrive on independent valid/data streams, with no fixed order and no alignment between sources. Each source has its own small FIFO. Source 0 is the reference.

A reference primitive waits a programmable number of cycles at the head of its queue, so that late primitives from the other sources can arrive. After that wait, the block compares each other source's oldest primitive with the reference timestamp. Primitives that are too old are thrown away and counted as unmatched. Primitives inside the programmable window add their condition bits to a combined condition vector. A programmable table of mask/value entries turns that vector into a 6-bit trigger word. The word is issued with the reference timestamp as a one-cycle pulse on the 25 ns clock.

The window, the hold time, the table and two event counters sit behind a simple register port.

Top module: `trig_time_matcher`

## Requirements
- R1: After reset, `trig_valid` is low, and the unmatched counter (address 2) and trigger counter (address 3) both read 0.
- R2: Let dt = source timestamp − reference timestamp, taken modulo 2^16 as a signed value. A non-reference head primitive is in the window when |dt| ≤ window (address 0). An in-window source s places its condition in bits [8s+7:8s] of the combined vector. The reference condition always occupies bits [7:0], and absent or out-of-window sources contribute zeros.
- R3: Table entry e has its mask at address 8+3e, its value at 9+3e, and its code word at 10+3e, where bits [5:0] are the code and bit 6 is the enable. An enabled entry matches when (combined AND mask) equals value. The enabled matching entry with the lowest number supplies `trig_word`, and disabled entries never match.
- R4: When no enabled entry matches, no trigger is issued and the trigger counter does not change.
- R5: Each reference primitive that matches produces exactly one single-cycle `trig_valid` pulse. `trig_time` carries that reference primitive's timestamp.
- R6: A non-reference head primitive with dt < −window is discarded and adds one to the unmatched counter. A primitive with dt > window stays queued for later reference primitives.
- R7: A primitive that arrives when its source FIFO is full is dropped and adds one to the unmatched counter.
- R8: The trigger counter increments by one for each issued trigger and holds its value otherwise.
- R9: Once a reference primitive is at the head of its queue, it is resolved only after the hold count (address 1) has elapsed. With no stale entries present, `trig_valid` rises hold+1 clock edges after the edge that accepted the primitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz (25 ns) clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | NSRC | Primitive strobe, one bit per source |
| src_cond | input | NSRC*CW | Condition fields, source s in bits [CW*s +: CW] |
| src_time | input | NSRC*TW | Fine timestamps, source s in bits [TW*s +: TW] |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| trig_valid | output | 1 | Trigger pulse |
| trig_word | output | 6 | Trigger code |
| trig_time | output | TW | Timestamp of the matched reference primitive |

## Verification
The bench builds the block with four sources, 8-bit conditions, 16-bit timestamps and an eight-entry table, but with a FIFO depth of 2. The short FIFO lets three pushes to one source reach the overflow drop. The bench then sends a later reference so that the two queued entries expire as stale in one pass. A window of 16 ticks puts the inclusive boundary, the just-outside future primitive that must stay queued, and a timestamp pair that straddles the 16-bit wrap all within a few directed events. A hold count of 6 makes the resolution latency long enough to measure edge by edge.

// File: rtl/trig_time_matcher.sv
module trig_time_matcher #(
  parameter int NSRC  = 4,
  parameter int CW    = 8,
  parameter int TW    = 16,
  parameter int DEPTH = 4,
  parameter int NENT  = 8,
  parameter int WINW  = 12,
  parameter int HOLDW = 8,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      src_valid,
  input  logic [NSRC*CW-1:0]   src_cond,
  input  logic [NSRC*TW-1:0]   src_time,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [DW-1:0]        cfg_wdata,
  output logic [DW-1:0]        cfg_rdata,
  output logic                 trig_valid,
  output logic [5:0]           trig_word,
  output logic [TW-1:0]        trig_time
);
  localparam int PW    = $clog2(DEPTH);
  localparam int CMBW  = NSRC * CW;
  localparam int TBASE = 8;

  logic [WINW-1:0]  win_r;
  logic [HOLDW-1:0] hold_r;
  logic [CMBW-1:0]  mask_r [NENT];
  logic [CMBW-1:0]  val_r  [NENT];
  logic [5:0]       code_r [NENT];
  logic [NENT-1:0]  en_r;
  logic [31:0]      unm_cnt, trg_cnt;
  logic [HOLDW-1:0] age;

  logic [TW-1:0]    head_t [NSRC];
  logic [CW-1:0]    head_c [NSRC];
  logic [NSRC-1:0]  hv, full, drop, pop, stale, inwin;
  logic [NSRC*(PW+1)-1:0] occ_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_r  <= '0;
      hold_r <= '0;
      en_r   <= '0;
      for (int e = 0; e < NENT; e++) begin
        mask_r[e] <= '0;
        val_r[e]  <= '0;
        code_r[e] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr == AW'(0)) win_r  <= cfg_wdata[WINW-1:0];
      if (cfg_addr == AW'(1)) hold_r <= cfg_wdata[HOLDW-1:0];
      for (int e = 0; e < NENT; e++) begin
        if (cfg_addr == AW'(TBASE + 3*e))     mask_r[e] <= cfg_wdata[CMBW-1:0];
        if (cfg_addr == AW'(TBASE + 3*e + 1)) val_r[e]  <= cfg_wdata[CMBW-1:0];
        if (cfg_addr == AW'(TBASE + 3*e + 2)) begin
          code_r[e] <= cfg_wdata[5:0];
          en_r[e]   <= cfg_wdata[6];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == AW'(0)) cfg_rdata = DW'(win_r);
    if (cfg_addr == AW'(1)) cfg_rdata = DW'(hold_r);
    if (cfg_addr == AW'(2)) cfg_rdata = DW'(unm_cnt);
    if (cfg_addr == AW'(3)) cfg_rdata = DW'(trg_cnt);
    for (int e = 0; e < NENT; e++) begin
      if (cfg_addr == AW'(TBASE + 3*e))     cfg_rdata = DW'(mask_r[e]);
      if (cfg_addr == AW'(TBASE + 3*e + 1)) cfg_rdata = DW'(val_r[e]);
      if (cfg_addr == AW'(TBASE + 3*e + 2)) cfg_rdata = DW'({en_r[e], code_r[e]});
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_q
    logic [CW+TW-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [PW:0]      cnt;
    logic             push;

    assign hv[s]   = (cnt != '0);
    assign full[s] = (cnt == (PW+1)'(DEPTH));
    assign drop[s] = src_valid[s] & full[s];
    assign push    = src_valid[s] & ~full[s];
    assign {head_c[s], head_t[s]} = mem[rp];
    assign occ_flat[s*(PW+1) +: PW+1] = cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) begin
          mem[wp] <= {src_cond[s*CW +: CW], src_time[s*TW +: TW]};
          wp      <= wp + 1'b1;
        end
        if (pop[s]) rp <= rp + 1'b1;
        cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop[s]);
      end
    end
  end

  logic                 ready, fire, hit;
  logic [5:0]           hcode;
  logic [CMBW-1:0]      comb;
  logic signed [TW-1:0] wv, d;
  logic [7:0]           unm_inc;

  assign ready = hv[0] && (age >= hold_r);
  assign wv    = $signed({{(TW-WINW){1'b0}}, win_r});

  always_comb begin
    stale = '0;
    inwin = '0;
    comb  = '0;
    d     = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (s == 0) begin
        inwin[s] = hv[s];
      end else begin
        d        = $signed(head_t[s] - head_t[0]);
        stale[s] = hv[s] && (d < -wv);
        inwin[s] = hv[s] && (d >= -wv) && (d <= wv);
      end
      comb[s*CW +: CW] = inwin[s] ? head_c[s] : '0;
    end
  end

  always_comb begin
    hit   = 1'b0;
    hcode = '0;
    for (int e = NENT-1; e >= 0; e--) begin
      if (en_r[e] && ((comb & mask_r[e]) == val_r[e])) begin
        hit   = 1'b1;
        hcode = code_r[e];
      end
    end
  end

  assign fire = ready && (stale == '0);

  always_comb begin
    pop     = '0;
    unm_inc = '0;
    pop[0]  = fire;
    for (int s = 1; s < NSRC; s++)
      pop[s] = ready && (stale[s] || (fire && inwin[s]));
    for (int s = 0; s < NSRC; s++)
      unm_inc = unm_inc + 8'(ready & stale[s]) + 8'(drop[s]);
  end

  always_ff @(posedge clk) begin
    if (rst || pop[0])
      age <= '0;
    else if (hv[0] && age < hold_r)
      age <= age + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_valid <= 1'b0;
      trig_word  <= '0;
      trig_time  <= '0;
      unm_cnt    <= '0;
      trg_cnt    <= '0;
    end else begin
      trig_valid <= fire && hit;
      if (fire && hit) begin
        trig_word <= hcode;
        trig_time <= head_t[0];
        trg_cnt   <= trg_cnt + 1;
      end
      unm_cnt <= unm_cnt + 32'(unm_inc);
    end
  end
endmodule

module trig_time_matcher_chk #(
  parameter int NSRC  = 4,
  parameter int PW    = 2,
  parameter int DEPTH = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   trig_valid,
  input logic [31:0]            trg_cnt,
  input logic [31:0]            unm_cnt,
  input logic [NSRC*(PW+1)-1:0] occ
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!trig_valid && trg_cnt == 0 && unm_cnt == 0));

  assert_trig_counted_R8: assert property (@(posedge clk) disable iff (rst)
    trig_valid |-> trg_cnt == $past(trg_cnt) + 1);

  assert_trig_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !trig_valid |-> $stable(trg_cnt));

  assert_unmatched_monotonic_R6: assert property (@(posedge clk) disable iff (rst)
    unm_cnt >= $past(unm_cnt));

  for (genvar s = 0; s < NSRC; s++) begin : g_occ
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
      occ[s*(PW+1) +: PW+1] <= (PW+1)'(DEPTH));
  end
endmodule

bind trig_time_matcher trig_time_matcher_chk #(.NSRC(NSRC), .PW(PW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .trig_valid(trig_valid),
  .trg_cnt(trg_cnt), .unm_cnt(unm_cnt), .occ(occ_flat)
);

// File: tb/trig_time_matcher_test.sv
module trig_time_matcher_test;
  localparam int CLK_PERIOD = 25;
  localparam int NSRC = 4, CW = 8, TW = 16, DEPTH = 2, NENT = 8, AW = 6, DW = 32;
  localparam int HOLD = 6, WIN = 16;

  logic              clk = 0, rst = 1;
  logic [NSRC-1:0]   src_valid = '0;
  logic [NSRC*CW-1:0] src_cond = '0;
  logic [NSRC*TW-1:0] src_time = '0;
  logic              cfg_we = 0;
  logic [AW-1:0]     cfg_addr = '0;
  logic [DW-1:0]     cfg_wdata = '0;
  logic [DW-1:0]     cfg_rdata;
  logic              trig_valid;
  logic [5:0]        trig_word;
  logic [TW-1:0]     trig_time;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [21:0] sb_q [$];
  logic [31:0] m_mask [NENT];
  logic [31:0] m_val  [NENT];
  logic [5:0]  m_code [NENT];
  logic        m_en   [NENT];

  trig_time_matcher #(.NSRC(NSRC), .CW(CW), .TW(TW), .DEPTH(DEPTH), .NENT(NENT),
                      .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_cond(src_cond),
    .src_time(src_time), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig_valid(trig_valid),
    .trig_word(trig_word), .trig_time(trig_time));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = AW'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic set_entry(input int e, input logic [31:0] m, input logic [31:0] v,
                           input logic [5:0] c, input logic en);
    m_mask[e] = m; m_val[e] = v; m_code[e] = c; m_en[e] = en;
    wr(8 + 3*e, m);
    wr(9 + 3*e, v);
    wr(10 + 3*e, {25'd0, en, c});
  endtask

  task automatic push(input int s, input logic [7:0] c, input logic [15:0] t);
    @(negedge clk);
    src_valid[s] = 1'b1;
    src_cond[s*CW +: CW] = c;
    src_time[s*TW +: TW] = t;
    @(negedge clk);
    src_valid = '0;
  endtask

  // Reference push with the combined vector the requirements predict (R2, R3)
  task automatic send_ref(input logic [7:0] c, input logic [15:0] t, input logic [31:0] cmb);
    bit found = 0;
    logic [5:0] code = '0;
    for (int e = 0; e < NENT; e++)
      if (!found && m_en[e] && ((cmb & m_mask[e]) == m_val[e])) begin
        found = 1; code = m_code[e];
      end
    if (found) sb_q.push_back({code, t});
    push(0, c, t);
    repeat (20) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && trig_valid) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 actual=unexpected trigger %0h expected=none", trig_word);
      end else begin
        logic [21:0] x;
        x = sb_q.pop_front();
        check("R3 trig_word", 32'(trig_word), 32'(x[21:16]));
        check("R5 trig_time", 32'(trig_time), 32'(x[15:0]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R5 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    for (int e = 0; e < NENT; e++) begin
      m_mask[e] = '0; m_val[e] = '0; m_code[e] = '0; m_en[e] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 trig_valid", 32'(trig_valid), 0);
    rd(2, v); check("R1 unmatched", v, 0);
    rd(3, v); check("R1 triggers", v, 0);

    wr(0, WIN);
    wr(1, HOLD);
    set_entry(0, 32'h0000_0101, 32'h0000_0101, 6'h11, 1);
    set_entry(1, 32'h0000_0001, 32'h0000_0001, 6'h05, 1);
    set_entry(2, 32'h00FF_0000, 32'h0004_0000, 6'h2A, 1);
    set_entry(3, 32'h0, 32'h0, 6'h3F, 0);   // R3 disabled catch-all never used

    // R2/R3: coincidence, entry 0 wins over entry 1
    push(1, 8'h01, 16'd1010);
    send_ref(8'h01, 16'd1000, 32'h0000_0101);
    // R2: dt exactly equal to window counts
    push(1, 8'h01, 16'd2016);
    send_ref(8'h01, 16'd2000, 32'h0000_0101);
    // R6: dt = window+1 stays queued, reference alone hits entry 1
    push(1, 8'h01, 16'd3017);
    send_ref(8'h01, 16'd3000, 32'h0000_0001);
    // R6: kept primitive now matches the next reference
    push(2, 8'h04, 16'd3020);
    send_ref(8'h01, 16'd3020, 32'h0004_0101);
    // R6: stale primitive discarded
    push(1, 8'h01, 16'd4000);
    send_ref(8'h01, 16'd4100, 32'h0000_0001);
    rd(2, v); check("R6 unmatched after stale", v, 1);
    // R4: no table match
    send_ref(8'h02, 16'd5000, 32'h0000_0002);
    rd(3, v); check("R4 trigger count unchanged", v, 5);
    // R2: timestamp wrap
    push(1, 8'h01, 16'h0004);
    send_ref(8'h01, 16'hFFFC, 32'h0000_0101);
    // R7: overflow drop then both queued expire
    push(3, 8'h01, 16'd6000);
    push(3, 8'h01, 16'd6001);
    push(3, 8'h01, 16'd6002);
    rd(2, v); check("R7 unmatched after drop", v, 2);
    send_ref(8'h01, 16'd6100, 32'h0000_0001);
    rd(2, v); check("R6 unmatched after expiry", v, 4);

    // R9: latency from accepting edge
    sb_q.push_back({6'h05, 16'd7000});
    @(negedge clk);
    src_valid[0] = 1'b1; src_cond[7:0] = 8'h01; src_time[15:0] = 16'd7000;
    @(posedge clk);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      src_valid = '0;
      if (trig_valid) break;
      n++;
    end
    check("R9 latency edges", n, HOLD + 1);
    repeat (20) @(negedge clk);

    rd(3, v); check("R8 trigger count", v, 8);
    rd(2, v); check("R6 final unmatched", v, 4);
    check("R5 scoreboard drained", sb_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule